// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a processor's instruction sequencer and decides, each time an instruction completes, whether the sequencer fetches the next instruction or runs an interrupt cycle. Four request lines come in. Line 0 (hardware failure) has the highest priority, then line 1 (timer), line 2 (I/O) and line 3 (program fault). A rising edge on a line makes that source pending. When the controller takes an interrupt, it pulses a context-save strobe and then a PC-load strobe. The PC-load strobe comes with that source's fixed handler address.

A mode input selects one of two policies:

- **Sequential mode.** While any handler runs, no new interrupt cycle starts. Requests keep accumulating, and once the handler returns they are served one at a time in arrival order.
- **Nested mode.** A request with a strictly higher priority preempts the running handler. An internal stack of active levels then lets each return-from-interrupt resume the handler it interrupted, with a restore strobe.

Storing the context itself is left to the surrounding logic.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, fetch_go, save_ctx, load_pc, restore_ctx and active_vld are all low, with nothing pending and the level stack empty.
- R2: instr_end with no eligible pending request (and iret low, controller idle) raises fetch_go combinationally in that same cycle, and no interrupt cycle follows.
- R3: instr_end with an eligible request holds fetch_go low. save_ctx is then high for exactly the next cycle, and load_pc for the cycle after that. During load_pc, vector equals 0x010 + 8 × source (0x010, 0x018, 0x020, 0x028 for sources 0 to 3), and active_src shows that source.
- R4: A source becomes pending only on a low-to-high transition of its request line. A line held high after being served does not cause a second interrupt.
- R5: Pending requests are examined only in a cycle with instr_end high. Without it, no interrupt cycle starts.
- R6: In sequential mode (nest_mode = 0), no interrupt cycle starts while a handler is active. Requests arriving meanwhile stay pending and are served after iret.
- R7: In sequential mode, pending sources are served in order of arrival. Sources that rise in the same cycle are ordered by priority, lower index first.
- R8: In nested mode (nest_mode = 1), a pending source with a strictly lower index than the active one preempts it at the next instr_end. A source of equal or higher index waits, and fetch_go is given instead.
- R9: An accepted iret (idle, level stack non-empty) pops one level. restore_ctx pulses one cycle later, when active_src/active_vld show the resumed level. An iret with an empty stack produces no restore_ctx.
- R10: If iret and instr_end are high in the same cycle, iret wins: fetch_go stays low and no interrupt cycle starts from that cycle.
- R11: instr_end during the save or load cycle is ignored: fetch_go stays low and no further cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 4 | Request lines, bit 0 highest priority |
| nest_mode | input | 1 | 0 = sequential, 1 = nested priority |
| instr_end | input | 1 | Instruction boundary strobe |
| iret | input | 1 | Return-from-interrupt strobe |
| fetch_go | output | 1 | Proceed with the next instruction fetch |
| save_ctx | output | 1 | Save the interrupted context (one cycle) |
| load_pc | output | 1 | Load PC from vector (one cycle) |
| vector | output | 12 | Handler start address, valid with load_pc |
| restore_ctx | output | 1 | Restore context of the resumed level |
| active_vld | output | 1 | A handler level is active |
| active_src | output | 2 | Source of the innermost active level |

## Verification
A corrupted pending bit or arrival queue entry shows up at the next instr_end. The symptom is a wrong or missing save_ctx, or a wrong vector two cycles later. A level stack that is wrong shows on active_src straight away, and on the restore/resume order at the next iret. The bench therefore compares every output in every cycle against its own model of the pending set, the arrival queue and the stack. As a result, a fault is caught within a few cycles of the first stimulus that exposes it.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_SAVE = 2'd1,
    CYC_LOAD = 2'd2
  } icyc_t;

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] fresh
);

  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] kept;

  always_comb begin
    rise   = req & ~req_q;
    kept   = pend_q & ~clr_mask;
    pend_d = kept | rise;
    fresh  = rise & ~kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R4
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == req_q) |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/irq_order_fifo.sv
module irq_order_fifo #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned DEPTH = NSRC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    pop,
  input  logic [NSRC-1:0]         push_mask,
  output logic [$clog2(NSRC)-1:0] head,
  output logic                    nempty
);

  localparam int unsigned SRC_W = $clog2(NSRC);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [SRC_W-1:0] ent_q [DEPTH];
  logic [SRC_W-1:0] ent_d [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    ent_d = ent_q;
    cnt_d = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      if (pop && (cnt_q != '0)) begin
        for (int i = 0; i < int'(DEPTH) - 1; i++) begin
          ent_d[i] = ent_q[i+1];
        end
        cnt_d = cnt_q - 1'b1;
      end
      for (int s = 0; s < int'(NSRC); s++) begin
        if (push_mask[s] && (cnt_d < CNT_W'(DEPTH))) begin
          ent_d[cnt_d[IDX_W-1:0]] = SRC_W'(s);
          cnt_d = cnt_d + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      ent_q <= ent_d;
    end
  end

  assign head   = ent_q[0];
  assign nempty = (cnt_q != '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R7
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(cnt_q) + $countones(push_mask)
                - int'(pop && (cnt_q != '0)) <= int'(DEPTH)));

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [$clog2(NSRC)-1:0] push_id,
  input  logic                    pop,
  output logic [$clog2(NSRC)-1:0] top_id,
  output logic                    top_vld
);

  localparam int unsigned SRC_W = $clog2(NSRC);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [SRC_W-1:0] lvl_q [DEPTH];
  logic [CNT_W-1:0] sp_q;
  logic [CNT_W-1:0] sp_d;
  logic [IDX_W-1:0] top_idx;
  logic             wr_en;

  always_comb begin
    wr_en = push && (sp_q < CNT_W'(DEPTH));
    sp_d  = sp_q;
    if (wr_en)                     sp_d = sp_q + 1'b1;
    else if (pop && (sp_q != '0))  sp_d = sp_q - 1'b1;
    top_idx = IDX_W'(sp_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) lvl_q[i] <= '0;
    end else begin
      sp_q <= sp_d;
      if (wr_en) lvl_q[sp_q[IDX_W-1:0]] <= push_id;
    end
  end

  assign top_vld = (sp_q != '0);
  assign top_id  = top_vld ? lvl_q[top_idx] : '0;

  // R8
  stack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (sp_q < CNT_W'(DEPTH)));

  // R8
  preempt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && top_vld) |-> (push_id < top_id));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC       = 4,
  parameter int unsigned STK_DEPTH  = 4,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned VEC_BASE   = 32'h010,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         irq_req,
  input  logic                    nest_mode,
  input  logic                    instr_end,
  input  logic                    iret,
  output logic                    fetch_go,
  output logic                    save_ctx,
  output logic                    load_pc,
  output logic [ADDR_W-1:0]       vector,
  output logic                    restore_ctx,
  output logic                    active_vld,
  output logic [$clog2(NSRC)-1:0] active_src
);

  localparam int unsigned SRC_W = $clog2(NSRC);

  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   fresh;
  logic [NSRC-1:0]   clr_mask;
  logic [SRC_W-1:0]  fifo_head;
  logic              fifo_nempty;
  logic [SRC_W-1:0]  top_id;
  logic              top_vld;
  logic [SRC_W-1:0]  hp_id;
  logic              hp_vld;
  logic [SRC_W-1:0]  cand_id;
  logic              cand_vld;
  logic              idle;
  logic              take;
  logic              iret_ok;
  icyc_t             cyc_q;
  icyc_t             cyc_d;
  logic [SRC_W-1:0]  vec_id_q;
  logic              rest_q;
  logic [ADDR_W-1:0] vec_tbl [NSRC];

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .clr_mask (clr_mask),
    .pend     (pend),
    .fresh    (fresh)
  );

  irq_order_fifo #(.NSRC(NSRC), .DEPTH(NSRC)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (nest_mode),
    .pop       (take && !nest_mode),
    .push_mask (fresh),
    .head      (fifo_head),
    .nempty    (fifo_nempty)
  );

  irq_lvl_stack #(.NSRC(NSRC), .DEPTH(STK_DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take),
    .push_id (cand_id),
    .pop     (iret_ok),
    .top_id  (top_id),
    .top_vld (top_vld)
  );

  for (genvar g = 0; g < int'(NSRC); g++) begin : g_vec
    assign vec_tbl[g] = ADDR_W'(VEC_BASE + g * VEC_STRIDE);
  end

  // highest-priority pending source (lowest index)
  always_comb begin
    hp_id  = '0;
    hp_vld = 1'b0;
    for (int i = int'(NSRC) - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hp_id  = SRC_W'(i);
        hp_vld = 1'b1;
      end
    end
  end

  always_comb begin
    if (nest_mode) begin
      cand_id  = hp_id;
      cand_vld = hp_vld && (!top_vld || (hp_id < top_id));
    end else begin
      cand_id  = fifo_head;
      cand_vld = fifo_nempty && !top_vld;
    end
    idle     = (cyc_q == CYC_IDLE);
    take     = idle && instr_end && !iret && cand_vld;
    iret_ok  = idle && iret && top_vld;
    fetch_go = idle && instr_end && !iret && !cand_vld;
    clr_mask = take ? (NSRC'(1) << cand_id) : '0;
  end

  always_comb begin
    cyc_d = cyc_q;
    unique case (cyc_q)
      CYC_IDLE: if (take) cyc_d = CYC_SAVE;
      CYC_SAVE: cyc_d = CYC_LOAD;
      CYC_LOAD: cyc_d = CYC_IDLE;
      default:  cyc_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= CYC_IDLE;
      vec_id_q <= '0;
      rest_q   <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      rest_q <= iret_ok;
      if (take) vec_id_q <= cand_id;
    end
  end

  assign save_ctx    = (cyc_q == CYC_SAVE);
  assign load_pc     = (cyc_q == CYC_LOAD);
  assign vector      = load_pc ? vec_tbl[vec_id_q] : '0;
  assign restore_ctx = rest_q;
  assign active_vld  = top_vld;
  assign active_src  = top_id;

  // R3
  save_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_ctx |=> (load_pc && !save_ctx));

  // R5
  take_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_ctx) |-> $past(instr_end));

  // R6
  seq_no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_ctx && $past(!nest_mode)) |-> !$past(active_vld));

  // R9
  restore_after_iret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_ctx |-> $past(iret));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_ctx, load_pc, restore_ctx}));

  // R11
  no_fetch_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_ctx || load_pc) |-> !fetch_go);

endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;

  logic       clk;
  logic       rst_n;
  logic [3:0] irq_req;
  logic       nest_mode;
  logic       instr_end;
  logic       iret;
  logic       fetch_go;
  logic       save_ctx;
  logic       load_pc;
  logic [11:0] vector;
  logic       restore_ctx;
  logic       active_vld;
  logic [1:0] active_src;

  int errs;
  int checks;

  // bench reference model state
  logic [3:0] m_reqq;
  logic [3:0] m_pend;
  int         m_q [4];
  int         m_qn;
  int         m_stk [4];
  int         m_sp;
  int         m_st;
  int         m_vid;
  bit         m_rest;

  int vlog [256];
  int vn;

  irq_nest_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .nest_mode   (nest_mode),
    .instr_end   (instr_end),
    .iret        (iret),
    .fetch_go    (fetch_go),
    .save_ctx    (save_ctx),
    .load_pc     (load_pc),
    .vector      (vector),
    .restore_ctx (restore_ctx),
    .active_vld  (active_vld),
    .active_src  (active_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int vec_of(input int id);
    return 'h010 + 8 * id;
  endfunction

  task automatic model_cand(input bit md, output bit v, output int id);
    v  = 1'b0;
    id = 0;
    if (md) begin
      for (int i = 3; i >= 0; i--) if (m_pend[i]) begin v = 1'b1; id = i; end
      if (v && m_sp > 0 && id >= m_stk[m_sp-1]) v = 1'b0;
    end else if (m_qn > 0 && m_sp == 0) begin
      v  = 1'b1;
      id = m_q[0];
    end
  endtask

  task automatic step(input logic [3:0] rq, input bit ie, input bit ir, input bit md);
    bit cv;
    int cid;
    bit take;
    bit ir_ok;
    logic [3:0] rise;
    logic [3:0] clr;
    logic [3:0] keep;
    logic [3:0] newm;
    @(negedge clk);
    irq_req   = rq;
    instr_end = ie;
    iret      = ir;
    nest_mode = md;
    #1;
    model_cand(md, cv, cid);
    take  = (m_st == 0) && ie && !ir && cv;
    ir_ok = (m_st == 0) && ir && (m_sp > 0);
    chk("R2 fetch_go", int'(fetch_go), int'((m_st == 0) && ie && !ir && !cv));
    chk("R3 save_ctx", int'(save_ctx), int'(m_st == 1));
    chk("R3 load_pc", int'(load_pc), int'(m_st == 2));
    if (m_st == 2) chk("R3 vector", int'(vector), vec_of(m_vid));
    chk("R9 restore_ctx", int'(restore_ctx), int'(m_rest));
    chk("R8 active_vld", int'(active_vld), int'(m_sp > 0));
    if (m_sp > 0) chk("R8 active_src", int'(active_src), m_stk[m_sp-1]);
    if (load_pc && vn < 256) begin
      vlog[vn] = int'(vector);
      vn++;
    end
    // advance model to the state after the coming edge
    rise   = rq & ~m_reqq;
    clr    = take ? (4'b0001 << cid) : 4'b0000;
    keep   = m_pend & ~clr;
    newm   = rise & ~keep;
    m_pend = keep | rise;
    if (md) m_qn = 0;
    else begin
      if (take && m_qn > 0) begin
        for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
        m_qn--;
      end
      for (int s = 0; s < 4; s++) if (newm[s] && m_qn < 4) begin m_q[m_qn] = s; m_qn++; end
    end
    if (take) begin m_stk[m_sp] = cid; m_sp++; end
    else if (ir_ok) m_sp--;
    m_rest = ir_ok;
    if (take) m_vid = cid;
    m_st   = (m_st == 0) ? (take ? 1 : 0) : ((m_st == 1) ? 2 : 0);
    m_reqq = rq;
  endtask

  task automatic svc(input logic [3:0] rq, input bit md);
    step(rq, 1, 0, md);
    step(rq, 0, 0, md);
    step(rq, 0, 0, md);
  endtask

  task automatic ret(input logic [3:0] rq, input bit md);
    step(rq, 0, 1, md);
    step(rq, 0, 0, md);
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int base;
    logic [3:0] rq;
    errs = 0; checks = 0; vn = 0;
    m_reqq = '0; m_pend = '0; m_qn = 0; m_sp = 0; m_st = 0; m_vid = 0; m_rest = 1'b0;
    for (int i = 0; i < 4; i++) begin m_q[i] = 0; m_stk[i] = 0; end
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq_req = '0; nest_mode = 1'b0; instr_end = 1'b0; iret = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 fetch_go", int'(fetch_go), 0);
    chk("R1 save_ctx", int'(save_ctx), 0);
    chk("R1 load_pc", int'(load_pc), 0);
    chk("R1 restore_ctx", int'(restore_ctx), 0);
    chk("R1 active_vld", int'(active_vld), 0);
    rst_n = 1'b1;

    // R2 boundary with nothing pending
    step(4'b0000, 1, 0, 0);
    chk("R2 fetch_go idle", int'(fetch_go), 1);

    // R5 pending but no boundary
    step(4'b0100, 0, 0, 0);
    step(4'b0100, 0, 0, 0);
    chk("R5 no boundary no save", int'(save_ctx), 0);
    chk("R5 no boundary no fetch", int'(fetch_go), 0);

    // R3 interrupt cycle sequence for source 2
    step(4'b0100, 1, 0, 0);
    chk("R3 fetch_go low on take", int'(fetch_go), 0);
    step(4'b0100, 0, 0, 0);
    chk("R3 save pulse", int'(save_ctx), 1);
    step(4'b0100, 0, 0, 0);
    chk("R3 load pulse", int'(load_pc), 1);
    chk("R3 vector src2", int'(vector), 'h020);
    chk("R3 active_src src2", int'(active_src), 2);
    step(4'b0100, 0, 1, 0);
    step(4'b0100, 0, 0, 0);
    chk("R9 restore after iret", int'(restore_ctx), 1);
    chk("R9 stack empty", int'(active_vld), 0);
    // R4 held-high line does not re-pend
    step(4'b0100, 1, 0, 0);
    chk("R4 held line no second irq", int'(fetch_go), 1);

    // R7 arrival order: 3, then 1, then 0 and 2 together
    step(4'b0000, 0, 0, 0);
    step(4'b1000, 0, 0, 0);
    step(4'b1010, 0, 0, 0);
    step(4'b1111, 0, 0, 0);
    base = vn;
    svc(4'b1111, 0);
    // R6 handler active: boundary gives fetch, no new cycle
    step(4'b1111, 1, 0, 0);
    chk("R6 seq blocks while active", int'(fetch_go), 1);
    step(4'b1111, 0, 0, 0);
    chk("R6 no save while active", int'(save_ctx), 0);
    ret(4'b1111, 0);
    svc(4'b1111, 0); ret(4'b1111, 0);
    svc(4'b1111, 0); ret(4'b1111, 0);
    svc(4'b1111, 0); ret(4'b1111, 0);
    chk("R7 order first", vlog[base], 'h028);
    chk("R7 order second", vlog[base+1], 'h018);
    chk("R7 order third", vlog[base+2], 'h010);
    chk("R7 order fourth", vlog[base+3], 'h020);

    // R8 nested preemption
    step(4'b0000, 0, 0, 1);
    step(4'b0100, 0, 0, 1);
    svc(4'b0100, 1);
    step(4'b1100, 0, 0, 1);
    step(4'b1100, 1, 0, 1);
    chk("R8 lower waits", int'(fetch_go), 1);
    step(4'b1110, 0, 0, 1);
    svc(4'b1110, 1);
    chk("R8 timer preempts vector", int'(vector), 'h018);
    chk("R8 timer active", int'(active_src), 1);
    step(4'b1111, 0, 0, 1);
    svc(4'b1111, 1);
    chk("R8 hw preempts vector", int'(vector), 'h010);
    step(4'b1110, 0, 0, 1);
    step(4'b1111, 0, 0, 1);
    step(4'b1111, 1, 0, 1);
    chk("R8 equal waits", int'(fetch_go), 1);
    ret(4'b1111, 1);
    chk("R9 resumed timer restore", int'(restore_ctx), 1);
    chk("R9 resumed timer src", int'(active_src), 1);
    svc(4'b1111, 1);
    chk("R8 hw preempts again", int'(vector), 'h010);
    ret(4'b1111, 1);
    ret(4'b1111, 1);
    chk("R9 resumed io src", int'(active_src), 2);
    ret(4'b1111, 1);
    chk("R9 empty after pops", int'(active_vld), 0);
    svc(4'b1111, 1);
    chk("R8 prog fault served", int'(vector), 'h028);
    ret(4'b1111, 1);
    ret(4'b1111, 1);
    chk("R9 iret on empty no restore", int'(restore_ctx), 0);

    // R10 iret and boundary together
    step(4'b0000, 0, 0, 0);
    step(4'b0001, 0, 0, 0);
    step(4'b0001, 1, 1, 0);
    chk("R10 iret wins no fetch", int'(fetch_go), 0);
    step(4'b0001, 0, 0, 0);
    chk("R10 iret wins no save", int'(save_ctx), 0);
    // R11 boundary during interrupt cycle
    step(4'b0001, 1, 0, 0);
    step(4'b0001, 1, 0, 0);
    chk("R11 save cycle", int'(save_ctx), 1);
    chk("R11 no fetch in save", int'(fetch_go), 0);
    step(4'b0001, 1, 0, 0);
    chk("R11 no fetch in load", int'(fetch_go), 0);
    chk("R11 vector hw", int'(vector), 'h010);
    ret(4'b0001, 0);

    // constrained random phases, alternating mode
    rq = 4'b0000;
    for (int ph = 0; ph < 6; ph++) begin
      for (int c = 0; c < 600; c++) begin
        for (int b = 0; b < 4; b++) if (($urandom % 8) == 0) rq[b] = ~rq[b];
        step(rq, ($urandom % 2) == 0, ($urandom % 8) == 0, (ph % 2) == 1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule